// File: doc/BRIEF.md
# Dual-CPU Interrupt Source Mapper

This block routes 64 level-sensitive interrupt sources to two processors. Each processor has its own register bank. The bank holds a mask word, a 3-bit route field for every source, a mailbox word and a latched bridge-pending word. Per processor, a source counts as pending when any of these is true: its raw line is high, its bridge-pending bit is set, or (for one chosen source) any of the upper 16 mailbox bits is set. A pending source that is not masked shows in that processor's status word. It then drives the output line that its route field selects. There are five lines per processor.

Each processor also gets a combinational index of its highest-numbered status bit, plus a flag that says whether any status bit is set. Software reaches the banks over a simple read/write register port. The port gives a processor number and a byte offset. Read data returns one cycle after the request.

Top module: `irq_route_mapper`

## Requirements
- R1: After reset, every mask bit is 1 and every route field is 0. The mailbox and bridge-pending words read 0, all `irq_line` bits are low and every `top_vld` bit is low.
- R2: Offset 0x000 is the mask word. A bit value of 1 blocks that source for that processor, and 0 lets it through. A blocked source reaches no output line and no priority index.
- R3: The route field of source i sits in bits [2:0] of offset 0x200 + 8*i. A value of 0 to 4 selects output line 0 to 4 of that processor. A value of 5, 6 or 7 drives no line, but the source still takes part in the priority index.
- R4: Output line k of processor c is bit c*5+k of `irq_line`. It is high when at least one source with status bit set has route value k.
- R5: For processor c, `top_idx[c*6 +: 6]` gives the highest-numbered set status bit and `top_vld[c]` is 1. When no status bit is set, `top_vld[c]` is 0 and the index is 0.
- R6: Offset 0x008 reads the status word: the pending sources ANDed with the inverse of the mask.
- R7: A write to offset 0x010 sets the ones of the write data into the mailbox word, and a read of 0x010 returns the word. A write to offset 0x018 clears the bits where the data holds ones. If any of mailbox bits 63..48 is set, source 26 is pending for that processor; lower mailbox bits drive no source.
- R8: Input `bridge_evt` sets bits in the bridge-pending word of every processor. The word reads at offset 0x020, and its set bits are pending sources. A write to offset 0x028 through either processor number clears the bits where the data holds ones, in both banks in the same cycle. A new event in that cycle wins over the clear.
- R9: A read request raises `reg_rvalid` with `reg_rdata` in the following cycle only. Offsets that are not mapped, and offsets 0x018 and 0x028, read as 0.
- R10: A write carrying one processor number changes only that processor's mask, route and mailbox state.
- R11: A write to a mask or route register changes the outputs right after the clock edge that accepts the write. Before that edge the outputs are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_raw | input | 64 | Raw level-sensitive interrupt sources |
| bridge_evt | input | 64 | Bridge interrupt events, latched into every bank |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_cpu | input | 1 | Processor bank select |
| reg_addr | input | 10 | Byte offset inside the bank |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data, registered |
| reg_rvalid | output | 1 | Read data valid, one cycle after `reg_re` |
| irq_line | output | 10 | Five output lines per processor, processor c at bits c*5+4..c*5 |
| top_idx | output | 12 | Highest pending source index, six bits per processor |
| top_vld | output | 2 | Any status bit set, one bit per processor |

## Verification
The line outputs and the priority index are combinational over registered state. A mask, route or mailbox write therefore shows on them one edge after it is accepted. The bench drives inputs on the falling edge and samples at the next falling edge, one cycle after the write. One test samples before that edge as well, to confirm the old value still holds. Read data is due in the cycle after the request, so the bench samples `reg_rdata` and `reg_rvalid` at the falling edge that follows the request edge. It also checks that `reg_rvalid` drops one cycle later. A bridge event and a bridge clear land at the same edge, and the bench reads both banks afterwards.

// File: rtl/irq_map_pkg.sv
package irq_map_pkg;

   // register kinds inside one processor bank
   typedef enum logic [2:0] {
      RK_NONE,
      RK_MASK,
      RK_STAT,
      RK_MBOX,
      RK_MCLR,
      RK_BPEND,
      RK_BCLR,
      RK_ROUTE
   } reg_kind_e;

   localparam int OFF_MASK   = 'h000;
   localparam int OFF_STAT   = 'h008;
   localparam int OFF_MBOX   = 'h010;
   localparam int OFF_MCLR   = 'h018;
   localparam int OFF_BPEND  = 'h020;
   localparam int OFF_BCLR   = 'h028;
   localparam int ROUTE_BASE = 'h200;

   function automatic reg_kind_e decode_kind(input logic [15:0] a, input int nsrc);
      int ai;
      ai = int'(a);
      if (ai == OFF_MASK)       return RK_MASK;
      else if (ai == OFF_STAT)  return RK_STAT;
      else if (ai == OFF_MBOX)  return RK_MBOX;
      else if (ai == OFF_MCLR)  return RK_MCLR;
      else if (ai == OFF_BPEND) return RK_BPEND;
      else if (ai == OFF_BCLR)  return RK_BCLR;
      else if (ai >= ROUTE_BASE && ai < ROUTE_BASE + nsrc * 8 && a[2:0] == 3'b000)
         return RK_ROUTE;
      return RK_NONE;
   endfunction

endpackage

// File: rtl/irq_cpu_bank.sv
module irq_cpu_bank
   import irq_map_pkg::*;
#(
   parameter int NUM_SRC      = 64,
   parameter int ROUTE_W      = 3,
   parameter int ADDR_W       = 10,
   parameter int MBOX_HI_BITS = 16,
   parameter int MBOX_SRC     = 26
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_en,
   input  logic [ADDR_W-1:0]          addr,
   input  logic [NUM_SRC-1:0]         wdata,
   input  logic [NUM_SRC-1:0]         src_raw,
   input  logic [NUM_SRC-1:0]         bridge_evt,
   input  logic                       bclr_en,
   input  logic [NUM_SRC-1:0]         bclr_data,
   output logic [NUM_SRC-1:0]         mask_q,
   output logic [NUM_SRC-1:0]         status,
   output logic [NUM_SRC*ROUTE_W-1:0] route_flat,
   output logic [NUM_SRC-1:0]         rd_word
);

   localparam int RIDX_W = ADDR_W - 3;

   reg_kind_e                kind;
   logic [ADDR_W-1:0]        route_off;
   logic [RIDX_W-1:0]        route_idx;
   logic [NUM_SRC-1:0]       mbox_q;
   logic [NUM_SRC-1:0]       bpend_q;
   logic [NUM_SRC-1:0]       mbox_src;
   logic [NUM_SRC-1:0]       pend;
   logic [ROUTE_W-1:0]       route_q [NUM_SRC];

   assign kind      = decode_kind(16'(addr), NUM_SRC);
   assign route_off = addr - ADDR_W'(ROUTE_BASE);
   assign route_idx = route_off[ADDR_W-1:3];

   // mask, mailbox and bridge-pending words
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q  <= '1;
         mbox_q  <= '0;
         bpend_q <= '0;
      end else begin
         if (wr_en && kind == RK_MASK) mask_q <= wdata;
         if (wr_en && kind == RK_MBOX) mbox_q <= mbox_q | wdata;
         else if (wr_en && kind == RK_MCLR) mbox_q <= mbox_q & ~wdata;
         // a fresh event wins over a clear in the same cycle
         bpend_q <= (bpend_q & ~(bclr_en ? bclr_data : '0)) | bridge_evt;
      end
   end

   // per-source route fields
   for (genvar i = 0; i < NUM_SRC; i++) begin : g_route
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            route_q[i] <= '0;
         else if (wr_en && kind == RK_ROUTE && route_idx == RIDX_W'(i))
            route_q[i] <= wdata[ROUTE_W-1:0];
      end
      assign route_flat[i*ROUTE_W +: ROUTE_W] = route_q[i];
   end

   always_comb begin
      mbox_src           = '0;
      mbox_src[MBOX_SRC] = |mbox_q[NUM_SRC-1 -: MBOX_HI_BITS];
   end

   assign pend   = src_raw | bpend_q | mbox_src;
   assign status = pend & ~mask_q;

   always_comb begin
      rd_word = '0;
      case (kind)
         RK_MASK:  rd_word = mask_q;
         RK_STAT:  rd_word = status;
         RK_MBOX:  rd_word = mbox_q;
         RK_BPEND: rd_word = bpend_q;
         RK_ROUTE: begin
            for (int i = 0; i < NUM_SRC; i++)
               if (route_idx == RIDX_W'(i)) rd_word = NUM_SRC'(route_q[i]);
         end
         default:  rd_word = '0;
      endcase
   end

endmodule

// File: rtl/irq_line_merge.sv
module irq_line_merge #(
   parameter int NUM_SRC   = 64,
   parameter int ROUTE_W   = 3,
   parameter int NUM_LINES = 5
) (
   input  logic [NUM_SRC-1:0]         status,
   input  logic [NUM_SRC*ROUTE_W-1:0] route_flat,
   output logic [NUM_LINES-1:0]       lines
);

   for (genvar k = 0; k < NUM_LINES; k++) begin : g_line
      logic [NUM_SRC-1:0] hit;
      for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
         assign hit[i] = status[i] && (route_flat[i*ROUTE_W +: ROUTE_W] == ROUTE_W'(k));
      end
      assign lines[k] = |hit;
   end

endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
   parameter int NUM_SRC = 64,
   parameter int IDX_W   = $clog2(NUM_SRC)
) (
   input  logic [NUM_SRC-1:0] status,
   output logic [IDX_W-1:0]   idx,
   output logic               vld
);

   always_comb begin
      idx = '0;
      for (int i = 0; i < NUM_SRC; i++)
         if (status[i]) idx = IDX_W'(i);
   end

   assign vld = |status;

endmodule

// File: rtl/irq_route_mapper.sv
module irq_route_mapper
   import irq_map_pkg::*;
#(
   parameter int NUM_CPU      = 2,
   parameter int NUM_SRC      = 64,
   parameter int NUM_LINES    = 5,
   parameter int ROUTE_W      = 3,
   parameter int ADDR_W       = 10,
   parameter int MBOX_HI_BITS = 16,
   parameter int MBOX_SRC     = 26,
   parameter int CPU_W        = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
   parameter int IDX_W        = $clog2(NUM_SRC)
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [NUM_SRC-1:0]           src_raw,
   input  logic [NUM_SRC-1:0]           bridge_evt,
   input  logic                         reg_we,
   input  logic                         reg_re,
   input  logic [CPU_W-1:0]             reg_cpu,
   input  logic [ADDR_W-1:0]            reg_addr,
   input  logic [NUM_SRC-1:0]           reg_wdata,
   output logic [NUM_SRC-1:0]           reg_rdata,
   output logic                         reg_rvalid,
   output logic [NUM_CPU*NUM_LINES-1:0] irq_line,
   output logic [NUM_CPU*IDX_W-1:0]     top_idx,
   output logic [NUM_CPU-1:0]           top_vld
);

   // elaboration checks
   if (NUM_LINES > (1 << ROUTE_W)) begin : g_bad_lines
      $error("route field too narrow for line count");
   end
   if (MBOX_SRC >= NUM_SRC || MBOX_HI_BITS > NUM_SRC) begin : g_bad_mbox
      $error("mailbox source settings out of range");
   end
   if (ROUTE_BASE + NUM_SRC * 8 > (1 << ADDR_W)) begin : g_bad_addr
      $error("address width too small for route table");
   end

   logic [NUM_SRC-1:0]           bank_rd   [NUM_CPU];
   logic [NUM_CPU*NUM_SRC-1:0]   mask_flat;
   logic [NUM_CPU*NUM_SRC-1:0]   bpend_flat;
   logic                         bclr_en;
   logic [NUM_SRC-1:0]           rd_sel;

   assign bclr_en = reg_we && decode_kind(16'(reg_addr), NUM_SRC) == RK_BCLR;

   for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
      logic [NUM_SRC-1:0]         status;
      logic [NUM_SRC*ROUTE_W-1:0] route_flat;

      irq_cpu_bank #(
         .NUM_SRC(NUM_SRC), .ROUTE_W(ROUTE_W), .ADDR_W(ADDR_W),
         .MBOX_HI_BITS(MBOX_HI_BITS), .MBOX_SRC(MBOX_SRC)
      ) i_bank (
         .clk        (clk),
         .rst_n      (rst_n),
         .wr_en      (reg_we && reg_cpu == CPU_W'(c)),
         .addr       (reg_addr),
         .wdata      (reg_wdata),
         .src_raw    (src_raw),
         .bridge_evt (bridge_evt),
         .bclr_en    (bclr_en),
         .bclr_data  (reg_wdata),
         .mask_q     (mask_flat[c*NUM_SRC +: NUM_SRC]),
         .status     (status),
         .route_flat (route_flat),
         .rd_word    (bank_rd[c])
      );

      irq_line_merge #(
         .NUM_SRC(NUM_SRC), .ROUTE_W(ROUTE_W), .NUM_LINES(NUM_LINES)
      ) i_merge (
         .status     (status),
         .route_flat (route_flat),
         .lines      (irq_line[c*NUM_LINES +: NUM_LINES])
      );

      irq_prio_enc #(
         .NUM_SRC(NUM_SRC), .IDX_W(IDX_W)
      ) i_prio (
         .status (status),
         .idx    (top_idx[c*IDX_W +: IDX_W]),
         .vld    (top_vld[c])
      );

      assign bpend_flat[c*NUM_SRC +: NUM_SRC] = i_bank.bpend_q;
   end

   always_comb begin
      rd_sel = '0;
      for (int c = 0; c < NUM_CPU; c++)
         if (reg_cpu == CPU_W'(c)) rd_sel = bank_rd[c];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reg_rdata  <= '0;
         reg_rvalid <= 1'b0;
      end else begin
         reg_rvalid <= reg_re;
         if (reg_re) reg_rdata <= rd_sel;
      end
   end

endmodule

// File: rtl/irq_route_chk.sv
module irq_route_chk
   import irq_map_pkg::*;
#(
   parameter int NUM_CPU   = 2,
   parameter int NUM_SRC   = 64,
   parameter int NUM_LINES = 5,
   parameter int ADDR_W    = 10,
   parameter int CPU_W     = 1
) (
   input logic                         clk,
   input logic                         rst_n,
   input logic                         reg_we,
   input logic                         reg_re,
   input logic [CPU_W-1:0]             reg_cpu,
   input logic [ADDR_W-1:0]            reg_addr,
   input logic [NUM_SRC-1:0]           reg_wdata,
   input logic                         reg_rvalid,
   input logic [NUM_SRC-1:0]           bridge_evt,
   input logic [NUM_CPU*NUM_LINES-1:0] irq_line,
   input logic [NUM_CPU-1:0]           top_vld,
   input logic [NUM_CPU*NUM_SRC-1:0]   mask_flat,
   input logic [NUM_CPU*NUM_SRC-1:0]   bpend_flat
);

   reg_kind_e kind;
   assign kind = decode_kind(16'(reg_addr), NUM_SRC);

   // R9
   rd_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reg_re |=> reg_rvalid);
   // R9
   rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_re |=> !reg_rvalid);

   for (genvar c = 0; c < NUM_CPU; c++) begin : g_c
      // R5
      line_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (|irq_line[c*NUM_LINES +: NUM_LINES]) |-> top_vld[c]);
      // R2
      mask_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (reg_we && reg_cpu == CPU_W'(c) && kind == RK_MASK)
         |=> mask_flat[c*NUM_SRC +: NUM_SRC] == $past(reg_wdata));
      // R10
      bank_iso_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (reg_we && reg_cpu != CPU_W'(c))
         |=> $stable(mask_flat[c*NUM_SRC +: NUM_SRC]));
      // R8
      bclr_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (reg_we && kind == RK_BCLR)
         |=> (bpend_flat[c*NUM_SRC +: NUM_SRC] & $past(reg_wdata) & ~$past(bridge_evt)) == '0);
   end

endmodule

bind irq_route_mapper irq_route_chk #(
   .NUM_CPU(NUM_CPU), .NUM_SRC(NUM_SRC), .NUM_LINES(NUM_LINES),
   .ADDR_W(ADDR_W), .CPU_W(CPU_W)
) i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .reg_we     (reg_we),
   .reg_re     (reg_re),
   .reg_cpu    (reg_cpu),
   .reg_addr   (reg_addr),
   .reg_wdata  (reg_wdata),
   .reg_rvalid (reg_rvalid),
   .bridge_evt (bridge_evt),
   .irq_line   (irq_line),
   .top_vld    (top_vld),
   .mask_flat  (mask_flat),
   .bpend_flat (bpend_flat)
);

// File: tb/test_irq_route_mapper.sv
module test_irq_route_mapper;

   localparam int HALF = 10;  // 20 ns period, 50 MHz

   typedef struct packed {
      logic [63:0] src;
      logic [63:0] mask;
      logic        vld;
      logic [5:0]  idx;
   } vec_t;

   localparam vec_t VECS [6] = '{
      '{src: 64'h0,                   mask: 64'h0,                   vld: 1'b0, idx: 6'd0},
      '{src: 64'h8000_0000_0000_0004, mask: 64'h0,                   vld: 1'b1, idx: 6'd63},
      '{src: 64'h8000_0000_0000_0004, mask: 64'h8000_0000_0000_0000, vld: 1'b1, idx: 6'd2},
      '{src: 64'hFFFF_FFFF_FFFF_FFFF, mask: 64'hFFFF_FFFF_FFFF_FFFF, vld: 1'b0, idx: 6'd0},
      '{src: 64'h1,                   mask: 64'hFFFF_FFFF_FFFF_FFFE, vld: 1'b1, idx: 6'd0},
      '{src: 64'hF0,                  mask: 64'h30,                  vld: 1'b1, idx: 6'd7}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [63:0] src_raw = '0;
   logic [63:0] bridge_evt = '0;
   logic        reg_we = 1'b0;
   logic        reg_re = 1'b0;
   logic        reg_cpu = 1'b0;
   logic [9:0]  reg_addr = '0;
   logic [63:0] reg_wdata = '0;
   logic [63:0] reg_rdata;
   logic        reg_rvalid;
   logic [9:0]  irq_line;
   logic [11:0] top_idx;
   logic [1:0]  top_vld;

   int n_chk = 0;
   int n_err = 0;
   logic [63:0] rv;

   always #HALF clk = ~clk;

   irq_route_mapper i_irq_route_mapper (
      .clk(clk), .rst_n(rst_n), .src_raw(src_raw), .bridge_evt(bridge_evt),
      .reg_we(reg_we), .reg_re(reg_re), .reg_cpu(reg_cpu), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid),
      .irq_line(irq_line), .top_idx(top_idx), .top_vld(top_vld)
   );

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic cpu, input int addr, input logic [63:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_cpu = cpu; reg_addr = 10'(addr); reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic cpu, input int addr, output logic [63:0] d);
      @(negedge clk);
      reg_re = 1'b1; reg_cpu = cpu; reg_addr = 10'(addr);
      @(negedge clk);
      reg_re = 1'b0;
      check("R9 rvalid", 64'(reg_rvalid), 64'd1);
      d = reg_rdata;
   endtask

   initial begin
      #(HALF * 2 * 100000);
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      check("R1 lines", 64'(irq_line), 64'd0);
      check("R1 vld", 64'(top_vld), 64'd0);
      rd(1'b0, 'h000, rv); check("R1 mask", rv, '1);
      rd(1'b1, 'h228, rv); check("R1 route", rv, 64'd0);
      rd(1'b1, 'h010, rv); check("R1 mbox", rv, 64'd0);
      rd(1'b0, 'h020, rv); check("R1 bpend", rv, 64'd0);
      @(negedge clk);
      check("R9 rvalid drops", 64'(reg_rvalid), 64'd0);

      // R2 R5 vector table on cpu0, all routes 0 so line 0 follows vld
      for (int v = 0; v < 6; v++) begin
         src_raw = VECS[v].src;
         wr(1'b0, 'h000, VECS[v].mask);
         check("R5 vld", 64'(top_vld[0]), 64'(VECS[v].vld));
         check("R5 idx", 64'(top_idx[5:0]), 64'(VECS[v].idx));
         check("R2 line0", 64'(irq_line[4:0]), 64'(VECS[v].vld));
         check("R10 cpu1 quiet", 64'(irq_line[9:5]), 64'd0);
      end
      // R6 status read: src 0xF0, mask 0x30
      rd(1'b0, 'h008, rv); check("R6 status", rv, 64'hC0);

      // R3 R4 routing of source 5 on cpu0
      src_raw = 64'h20;
      wr(1'b0, 'h000, ~64'h20);
      wr(1'b0, 'h228, 64'd3);
      check("R3 route3", 64'(irq_line[4:0]), 64'h08);
      rd(1'b0, 'h228, rv); check("R3 route read", rv, 64'd3);
      wr(1'b0, 'h228, 64'd6);
      check("R3 route6 no line", 64'(irq_line[4:0]), 64'h00);
      check("R3 route6 vld", 64'(top_vld[0]), 64'd1);
      check("R3 route6 idx", 64'(top_idx[5:0]), 64'd5);
      wr(1'b0, 'h228, 64'd4);
      check("R4 route4", 64'(irq_line[4:0]), 64'h10);
      // R4 two sources on different lines
      src_raw = 64'h21;
      wr(1'b0, 'h000, ~64'h21);
      check("R4 two lines", 64'(irq_line[4:0]), 64'h11);
      check("R10 cpu1 quiet", 64'(irq_line[9:5]), 64'd0);

      // R11 timing of a route write
      @(negedge clk);
      reg_we = 1'b1; reg_cpu = 1'b0; reg_addr = 10'h228; reg_wdata = 64'd1;
      #1 check("R11 before edge", 64'(irq_line[4:0]), 64'h11);
      @(negedge clk);
      reg_we = 1'b0;
      check("R11 after edge", 64'(irq_line[4:0]), 64'h03);

      // R7 mailbox on cpu1
      src_raw = '0;
      wr(1'b0, 'h000, '1);
      wr(1'b1, 'h000, ~(64'd1 << 26));
      wr(1'b1, 'h010, 64'd1 << 48);
      check("R7 mbox line", 64'(irq_line[9:5]), 64'h01);
      check("R7 mbox idx", 64'(top_idx[11:6]), 64'd26);
      check("R10 cpu0 quiet", 64'(irq_line[4:0]), 64'd0);
      wr(1'b1, 'h018, '1);
      check("R7 cleared", 64'(top_vld[1]), 64'd0);
      wr(1'b1, 'h010, 64'h8);
      check("R7 low bit no source", 64'(top_vld[1]), 64'd0);
      rd(1'b1, 'h010, rv); check("R7 mbox read", rv, 64'h8);
      rd(1'b0, 'h010, rv); check("R10 cpu0 mbox", rv, 64'h0);
      wr(1'b1, 'h018, '1);
      rd(1'b1, 'h010, rv); check("R7 clear all", rv, 64'h0);

      // R8 bridge events
      wr(1'b1, 'h000, ~64'h200);
      @(negedge clk); bridge_evt = 64'h200;
      @(negedge clk); bridge_evt = '0;
      check("R8 bridge line", 64'(irq_line[9:5]), 64'h01);
      check("R8 bridge idx", 64'(top_idx[11:6]), 64'd9);
      rd(1'b0, 'h020, rv); check("R8 bank0 pend", rv, 64'h200);
      rd(1'b1, 'h020, rv); check("R8 bank1 pend", rv, 64'h200);
      // event and clear in the same cycle: event wins
      @(negedge clk);
      bridge_evt = 64'h200; reg_we = 1'b1; reg_cpu = 1'b1; reg_addr = 10'h028; reg_wdata = 64'h200;
      @(negedge clk);
      bridge_evt = '0; reg_we = 1'b0;
      rd(1'b0, 'h020, rv); check("R8 event wins", rv, 64'h200);
      wr(1'b1, 'h028, 64'h200);
      rd(1'b0, 'h020, rv); check("R8 clear bank0", rv, 64'h0);
      rd(1'b1, 'h020, rv); check("R8 clear bank1", rv, 64'h0);
      check("R8 line off", 64'(irq_line[9:5]), 64'h00);

      // R9 unmapped and write-only offsets
      rd(1'b0, 'h030, rv); check("R9 unmapped", rv, 64'h0);
      rd(1'b0, 'h018, rv); check("R9 wo offset", rv, 64'h0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
      $finish;
   end

endmodule